// File: doc/BRIEF.md
# Serial Configuration Stream Frame Checker

This block takes a configuration stream one bit at a time, qualified by a valid strobe, and splits it into its fields. While it waits for a header it skips runs of fill ones. When it sees the four-bit header pattern it captures a 24-bit length count. It then checks four fill bits and walks through a fixed number of data frames. Each frame is a zero start bit, a parameterised number of data bits and a four-bit trailer. After the last frame it checks a one-byte postamble.

Data bits leave the block on a serial output with a valid flag. A one-cycle pulse marks each frame whose trailer was accepted. A done flag rises once the whole load has checked out. The trailer is checked in one of two modes:
- Constant mode: the trailer must be the fixed code 0110.
- CRC mode: the trailer must equal the low four bits of a running 16-bit CRC. The CRC is taken over all data bits since the start of the load and is never reset between frames.

Any mismatch stops loading at once and drives the active-low init output low. The block then stays in a wait state that only a low level on the program input, or a reset, can end.

Top module: `cfg_frame_chk`

## Requirements
- R1: After reset, init_n is 1 and done, dout_valid and frame_done are 0.
- R2: A bit is taken only on a clock where din_valid is 1, and idle cycles have no effect. Before the header, any bits are skipped until the last four taken bits, oldest first, read 0,0,1,0.
- R3: The 24 bits after the header are the length count, most significant bit first. The next four bits must all be 1, and a 0 among them is an error.
- R4: Each frame opens with a start bit of 0, and a 1 in that position is an error.
- R5: Each of the FRAME_BITS data bits of a frame appears on dout, in stream order, with dout_valid high, in the cycle after the edge that took it. dout_valid is low in every other cycle.
- R6: With crc_mode = 0, the four trailer bits must arrive as 0,1,1,0. Each trailer bit is compared as it is taken, and the first wrong bit is an error.
- R7: With crc_mode = 1, the four trailer bits must equal CRC bits 3,2,1,0, in that order. The CRC is cleared to zero at reset and on a program pulse. It advances once per data bit b as crc = (crc << 1) ^ ((b ^ crc[15]) ? 16'h8005 : 0).
- R8: frame_done pulses for exactly one cycle, in the cycle after the last trailer bit of a frame whose trailer was accepted.
- R9: After FRAME_COUNT frames, the next eight bits must be 0,1,1,1,1,1,1,1, and a mismatch is an error. At the last of these bits it is also an error if the number of bits taken since the length count ended (fill, frames and postamble) differs from the length count.
- R10: done goes high in the cycle after the last postamble bit of an error-free load. It then stays high, and later stream bits are ignored.
- R11: An error drives init_n low from the cycle after the offending bit. It then holds init_n low, with no dout_valid or frame_done, whatever the stream does, for as long as prog_n stays high.
- R12: A clock with prog_n low clears any error and done, so that after that edge init_n is 1 and done is 0. It also restarts the search for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_n | input | 1 | Active-low restart, sampled on the clock |
| crc_mode | input | 1 | 1 selects running-CRC trailers, 0 selects the constant trailer |
| din | input | 1 | Stream bit |
| din_valid | input | 1 | Qualifies din |
| dout | output | 1 | Frame data bit |
| dout_valid | output | 1 | dout carries a data bit this cycle |
| frame_done | output | 1 | One-cycle pulse per accepted frame |
| done | output | 1 | Whole load checked without error |
| init_n | output | 1 | Low while the block is halted on an error |

## Verification
The assertions assume that crc_mode stays constant through a load and changes only while a program pulse is applied. They also assume that prog_n is synchronous to clk. The stimulus sets the mode before each load and never touches it during one, and it drives every input at the falling edge. Idle gaps of zero to two cycles, with junk on din, are placed between stream bits, which exercises the valid qualification. Each fault is placed at a single known bit, so that the cycle in which init_n falls can be predicted.

// File: rtl/cfg_frame_pkg.sv
`timescale 1ns/1ps
package cfg_frame_pkg;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_LEN,
    ST_FILL,
    ST_START,
    ST_DATA,
    ST_CHK,
    ST_POST,
    ST_DONE,
    ST_WAIT
  } ld_state_e;

  localparam int          LEN_W      = 24;
  localparam int          FILL_BITS  = 4;
  localparam int          TRAIL_BITS = 4;
  localparam int          POST_BITS  = 8;
  localparam logic [3:0]  HDR_CODE   = 4'b0010;
  localparam logic [3:0]  FIX_TRAIL  = 4'b0110;
  localparam logic [7:0]  POST_CODE  = 8'b0111_1111;

endpackage

// File: rtl/cfg_crc_serial.sv
`timescale 1ns/1ps
module cfg_crc_serial #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h8005,
  parameter int          OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [OUT_W-1:0] chk_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             fb;

  always_comb begin
    fb    = bit_in ^ crc_q[CRC_W-1];
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr || en) begin
      crc_q <= crc_d;
    end
  end

  assign chk_o = crc_q[OUT_W-1:0];

  // R7: the running check only moves on data bits or an explicit clear
  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(crc_q));

  p_crc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == '0));

endmodule

// File: rtl/cfg_len_track.sv
`timescale 1ns/1ps
module cfg_len_track #(
  parameter int LEN_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cap_en,
  input  logic cnt_en,
  input  logic bit_in,
  output logic last_hit
);

  localparam int            CW  = LEN_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [LEN_W-1:0] len_q, len_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    len_d = len_q;
    cnt_d = cnt_q;
    if (clr) begin
      len_d = '0;
      cnt_d = '0;
    end else begin
      if (cap_en) len_d = {len_q[LEN_W-2:0], bit_in};
      if (cnt_en) cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (clr || cap_en || cnt_en) begin
      len_q <= len_d;
      cnt_q <= cnt_d;
    end
  end

  // the bit being taken now is the final one the length count allows
  assign last_hit = ({1'b0, len_q} == (cnt_q + ONE));

  // R3: the captured length is frozen once the length field has passed
  p_len_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clr) |=> $stable(len_q));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/cfg_frame_chk.sv
`timescale 1ns/1ps
module cfg_frame_chk
  import cfg_frame_pkg::*;
#(
  parameter int          FRAME_BITS  = 16,
  parameter int          FRAME_COUNT = 4,
  parameter logic [15:0] CRC_POLY    = 16'h8005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic crc_mode,
  input  logic din,
  input  logic din_valid,
  output logic dout,
  output logic dout_valid,
  output logic frame_done,
  output logic done,
  output logic init_n
);

  localparam int CMAX = (FRAME_BITS > LEN_W) ? FRAME_BITS : LEN_W;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int FW   = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1;

  localparam logic [CW-1:0] LEN_LAST   = CW'(LEN_W - 1);
  localparam logic [CW-1:0] FILL_LAST  = CW'(FILL_BITS - 1);
  localparam logic [CW-1:0] DATA_LAST  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] TRAIL_LAST = CW'(TRAIL_BITS - 1);
  localparam logic [CW-1:0] POST_LAST  = CW'(POST_BITS - 1);
  localparam logic [FW-1:0] FRM_LAST   = FW'(FRAME_COUNT - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  ld_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] frm_q, frm_d;
  logic [2:0]    win_q, win_d;
  logic          dout_q, dout_d;
  logic          dv_q, dv_d;
  logic          fd_q, fd_d;

  logic          crc_clr, crc_en;
  logic          trk_clr, cap_en, cnt_en;
  logic [3:0]    crc_chk;
  logic          len_hit;
  logic          exp_trail;
  logic          exp_post;

  cfg_crc_serial #(
    .CRC_W (16),
    .POLY  (CRC_POLY),
    .OUT_W (TRAIL_BITS)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_i),
    .clr    (crc_clr),
    .en     (crc_en),
    .bit_in (din),
    .chk_o  (crc_chk)
  );

  cfg_len_track #(
    .LEN_W (LEN_W)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (trk_clr),
    .cap_en   (cap_en),
    .cnt_en   (cnt_en),
    .bit_in   (din),
    .last_hit (len_hit)
  );

  always_comb begin
    exp_trail = crc_mode ? crc_chk[2'd3 - cnt_q[1:0]] : FIX_TRAIL[2'd3 - cnt_q[1:0]];
    exp_post  = POST_CODE[3'd7 - cnt_q[2:0]];
  end

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    frm_d   = frm_q;
    win_d   = win_q;
    dout_d  = dout_q;
    dv_d    = 1'b0;
    fd_d    = 1'b0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    trk_clr = 1'b0;
    cap_en  = 1'b0;
    cnt_en  = 1'b0;
    if (!prog_n) begin
      st_d    = ST_HUNT;
      cnt_d   = '0;
      frm_d   = '0;
      win_d   = '1;
      crc_clr = 1'b1;
      trk_clr = 1'b1;
    end else if (din_valid) begin
      case (st_q)
        ST_HUNT: begin
          win_d = {win_q[1:0], din};
          if ({win_q, din} == HDR_CODE) begin
            st_d  = ST_LEN;
            cnt_d = '0;
          end
        end
        ST_LEN: begin
          cap_en = 1'b1;
          if (cnt_q == LEN_LAST) begin
            st_d  = ST_FILL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_FILL: begin
          cnt_en = 1'b1;
          if (!din) begin
            st_d = ST_WAIT;
          end else if (cnt_q == FILL_LAST) begin
            st_d  = ST_START;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_START: begin
          cnt_en = 1'b1;
          cnt_d  = '0;
          st_d   = din ? ST_WAIT : ST_DATA;
        end
        ST_DATA: begin
          cnt_en = 1'b1;
          crc_en = 1'b1;
          dv_d   = 1'b1;
          dout_d = din;
          if (cnt_q == DATA_LAST) begin
            st_d  = ST_CHK;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_CHK: begin
          cnt_en = 1'b1;
          if (din != exp_trail) begin
            st_d = ST_WAIT;
          end else if (cnt_q == TRAIL_LAST) begin
            fd_d  = 1'b1;
            cnt_d = '0;
            if (frm_q == FRM_LAST) begin
              st_d  = ST_POST;
              frm_d = '0;
            end else begin
              st_d  = ST_START;
              frm_d = frm_q + FW'(1);
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        ST_POST: begin
          cnt_en = 1'b1;
          if (din != exp_post) begin
            st_d = ST_WAIT;
          end else if (cnt_q == POST_LAST) begin
            st_d = len_hit ? ST_DONE : ST_WAIT;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          st_d = st_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      frm_q  <= '0;
      win_q  <= '1;
      dout_q <= 1'b0;
      dv_q   <= 1'b0;
      fd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      frm_q  <= frm_d;
      win_q  <= win_d;
      dout_q <= dout_d;
      dv_q   <= dv_d;
      fd_q   <= fd_d;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = dv_q;
  assign frame_done = fd_q;
  assign done       = (st_q == ST_DONE);
  assign init_n     = (st_q != ST_WAIT);

  // R2: a data bit on the output always traces back to a qualified input bit
  p_dv_strobe_r2: assert property (@(posedge clk) disable iff (!rst_i)
    dout_valid |-> $past(din_valid && prog_n));

  // R8: the frame pulse only follows a trailer bit
  p_fd_after_trail_r8: assert property (@(posedge clk) disable iff (!rst_i)
    frame_done |-> $past(st_q == ST_CHK));

  // R10: completion is sticky until a program pulse
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (done && prog_n) |=> done);

  // R11: the wait state holds and stays silent
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_i)
    (!init_n && prog_n) |=> !init_n);

  p_wait_quiet_r11: assert property (@(posedge clk) disable iff (!rst_i)
    !init_n |-> (!dout_valid && !frame_done));

  // R12: a program pulse always restarts cleanly
  p_restart_r12: assert property (@(posedge clk) disable iff (!rst_i)
    !prog_n |=> (init_n && !done));

endmodule

// File: tb/cfg_frame_chk_bench.sv
`timescale 1ns/1ps
module cfg_frame_chk_bench;

  localparam int FB = 16;
  localparam int FC = 4;

  localparam int F_NONE  = 0;
  localparam int F_CHK   = 1;
  localparam int F_START = 2;
  localparam int F_FILL  = 3;
  localparam int F_POST  = 4;
  localparam int F_LEN   = 5;

  logic clk = 1'b0;
  logic rst_n, prog_n, crc_mode, din, din_valid;
  logic dout, dout_valid, frame_done, done, init_n;

  always #2.5 clk = ~clk;

  cfg_frame_chk #(
    .FRAME_BITS  (FB),
    .FRAME_COUNT (FC)
  ) u_cfg_frame_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .crc_mode   (crc_mode),
    .din        (din),
    .din_valid  (din_valid),
    .dout       (dout),
    .dout_valid (dout_valid),
    .frame_done (frame_done),
    .done       (done),
    .init_n     (init_n)
  );

  int checks = 0;
  int fails  = 0;

  // reference model: one entry per stream bit
  bit q_bit[$];
  bit q_dv[$];
  bit q_dt[$];
  bit q_fd[$];
  int err_at;
  int done_at;
  bit exp_init;
  bit exp_done;
  logic [15:0] gap_lf = 16'hACE1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_outs(string tag, bit dv, bit dt, bit fd);
    chk(exp_init ? "R5" : "R11", "dout_valid", int'(dout_valid), int'(dv));
    if (dv) chk("R5", "dout", int'(dout), int'(dt));
    chk(exp_init ? "R8" : "R11", "frame_done", int'(frame_done), int'(fd));
    chk(tag, "init_n", int'(init_n), int'(exp_init));
    chk("R10", "done", int'(done), int'(exp_done));
  endtask

  task automatic push(bit b, bit dv, bit dt, bit fd, bit err_here, bit done_here);
    int idx;
    idx = q_bit.size();
    if (err_at >= 0 || err_here) begin
      dv = 1'b0;
      fd = 1'b0;
    end
    if (err_here && err_at < 0) err_at = idx;
    if (done_here && err_at < 0) done_at = idx;
    q_bit.push_back(b);
    q_dv.push_back(dv);
    q_dt.push_back(dt);
    q_fd.push_back(fd);
  endtask

  task automatic build(bit mode, int fault, bit noise);
    logic [15:0] crc;
    logic [15:0] pat;
    logic [7:0]  post;
    logic [3:0]  fix;
    int          len;
    bit          b, e, d;
    q_bit.delete(); q_dv.delete(); q_dt.delete(); q_fd.delete();
    err_at  = -1;
    done_at = -1;
    post = 8'b0111_1111;
    fix  = 4'b0110;
    if (noise) begin
      // skipped before the header (R2): no window reads 0010
      push(0,0,0,0,0,0); push(1,0,0,0,0,0); push(1,0,0,0,0,0); push(0,0,0,0,0,0);
      push(1,0,0,0,0,0); push(1,0,0,0,0,0);
    end
    for (int k = 0; k < 6; k++) push(1,0,0,0,0,0);
    push(0,0,0,0,0,0); push(0,0,0,0,0,0); push(1,0,0,0,0,0); push(0,0,0,0,0,0);
    len = 4 + FC * (FB + 5) + 8 + ((fault == F_LEN) ? 1 : 0);
    for (int k = 23; k >= 0; k--) push(len[k],0,0,0,0,0);
    for (int k = 0; k < 4; k++) begin
      b = !(fault == F_FILL && k == 2);
      push(b,0,0,0,!b,0);
    end
    crc = 16'h0000;
    for (int f = 0; f < FC; f++) begin
      b = (fault == F_START && f == 1);
      push(b,0,0,0,b,0);
      pat = 16'hA5C3 ^ (16'(f) * 16'h1357);
      for (int k = 0; k < FB; k++) begin
        d = pat[k % 16];
        push(d,1,d,0,0,0);
        crc = {crc[14:0], 1'b0} ^ ((d ^ crc[15]) ? 16'h8005 : 16'h0000);
      end
      for (int k = 0; k < 4; k++) begin
        e = mode ? crc[3-k] : fix[3-k];
        b = (fault == F_CHK && f == 2 && k == 1) ? !e : e;
        push(b,0,0,(k == 3),(b != e),0);
      end
    end
    for (int k = 0; k < 8; k++) begin
      e = post[7-k];
      b = (fault == F_POST && k == 3) ? !e : e;
      push(b,0,0,0,((b != e) || (k == 7 && fault == F_LEN)),(k == 7));
    end
    for (int k = 0; k < 8; k++) push(1,0,0,0,0,0);
  endtask

  task automatic run(string tag, bit mode);
    int gap;
    crc_mode = mode;
    for (int i = 0; i < q_bit.size(); i++) begin
      gap_lf = {gap_lf[14:0], gap_lf[15] ^ gap_lf[13] ^ gap_lf[12] ^ gap_lf[10]};
      gap = (gap_lf[1:0] == 2'd3) ? 0 : int'(gap_lf[1:0]);
      for (int g = 0; g < gap; g++) begin
        din       = gap_lf[5 + g];
        din_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        cmp_outs("R2", 1'b0, 1'b0, 1'b0);
      end
      din       = q_bit[i];
      din_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      if (err_at >= 0 && i >= err_at) exp_init = 1'b0;
      if (done_at >= 0 && i >= done_at) exp_done = 1'b1;
      cmp_outs(tag, q_dv[i], q_dt[i], q_fd[i]);
    end
    din_valid = 1'b0;
  endtask

  task automatic pulse_prog();
    prog_n    = 1'b0;
    din_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    prog_n   = 1'b1;
    exp_init = 1'b1;
    exp_done = 1'b0;
    chk("R12", "init_n after program", int'(init_n), 1);
    chk("R12", "done after program", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_n = 1'b1; crc_mode = 1'b0; din = 1'b0; din_valid = 1'b0;
    exp_init = 1'b1; exp_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "init_n", int'(init_n), 1);
    chk("R1", "done", int'(done), 0);
    chk("R1", "dout_valid", int'(dout_valid), 0);
    chk("R1", "frame_done", int'(frame_done), 0);

    build(1'b0, F_NONE, 1'b0); run("R6", 1'b0);   // constant trailers, full load
    chk("R10", "done held after start-up ones", int'(done), 1);
    pulse_prog();
    build(1'b1, F_NONE, 1'b0); run("R7", 1'b1);   // running CRC trailers
    chk("R10", "done after CRC load", int'(done), 1);
    pulse_prog();
    build(1'b0, F_NONE, 1'b1); run("R2", 1'b0);   // noise before header
    pulse_prog();
    build(1'b0, F_CHK, 1'b0);  run("R6", 1'b0);   // bad constant trailer
    chk("R11", "init_n held low", int'(init_n), 0);
    pulse_prog();
    build(1'b1, F_CHK, 1'b0);  run("R7", 1'b1);   // bad CRC trailer
    pulse_prog();
    build(1'b0, F_START, 1'b0); run("R4", 1'b0);  // bad start bit
    pulse_prog();
    build(1'b1, F_FILL, 1'b0); run("R3", 1'b1);   // bad fill bit
    pulse_prog();
    build(1'b0, F_POST, 1'b0); run("R9", 1'b0);   // bad postamble
    pulse_prog();
    build(1'b1, F_LEN, 1'b0);  run("R9", 1'b1);   // length mismatch
    pulse_prog();
    build(1'b1, F_NONE, 1'b0); run("R12", 1'b1);  // reload after errors
    chk("R12", "done after reload", int'(done), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule